// File: doc/BRIEF.md
# Buffered 8-bit PWM Timer

This block produces a pulse-width modulated output with 8 bits of resolution. A free-running 8-bit up-counter advances on ticks of a selectable source. An internal output flop inverts when the count equals the active duty value, and inverts again when the counter wraps from 255 to 0. The wrap also raises a one-cycle interrupt pulse. The output pin always drives the inverse of that flop. Software picks the flop's starting level, so it can produce either a positive or a negative pulse.

The duty value is double-buffered. While the timer runs, a write lands in a pending buffer and moves to the active compare register only at the next wrap, so a period never mixes two duty values. While the timer is stopped, the buffer is copied at once. Reading the duty register returns the active value. A small register port writes either the duty buffer or a control byte, and reads back either one.

The tick source is a prescaler on the system clock or an external slow-clock enable. The divide ratio is chosen in the control byte.

Top module: `pwm8_timer`

## Requirements
- R1: With control byte fields run = bit 0, initial level I = bit 1 and source select = bits 4:2, and active duty D, each period drives pwm_out to the inverse of I for D+1 ticks, then to I for the remaining 255-D ticks. With D = 255, pwm_out stays at the inverse of I for the whole period.
- R2: A period lasts 256 ticks. At the tick where the count is 255, the counter returns to 0, the output flop returns to I, and irq is high for exactly the one following clock cycle.
- R3: Source select code 0 gives one tick per 2048 clocks, 1 per 128, 2 per 32, 3 per 8, 4 per 2 and 5 one tick every clock. Codes 6 and 7 give one tick per clock in which slow_en is high. The prescaler is held at zero while the timer is stopped.
- R4: While the timer runs, a duty write (wr_en=1, wr_sel=0) only updates the pending buffer. The active duty, which rd_data shows when rd_sel=0, changes only at a wrap.
- R5: While the timer is stopped, a duty write reaches the active register in the following clock cycle.
- R6: If a duty write and a wrap share a clock edge, the wrap transfers the old buffer value and the new value waits for the next wrap.
- R7: While stopped, pwm_out holds its level. A stop write leaves the flop as it is. A control write made while running does not change the output flop.
- R8: A control write (wr_en=1, wr_sel=1) made while stopped clears the counter and loads the flop from bit 1. Setting bit 0 in that write starts a period from count 0. With rd_sel=1, rd_data shows bits 4:0 as written and bits 7:5 as 0.
- R9: After reset the flop is 0, so pwm_out is 1, irq is 0, and both registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_en | input | 1 | External slow-clock tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 duty buffer, 1 control byte |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 active duty, 1 control byte |
| rd_data | output | 8 | Read data |
| pwm_out | output | 1 | PWM output, the inverse of the output flop |
| irq | output | 1 | One-cycle pulse at each counter wrap |

## Verification
Two events can land on the same clock edge: a software duty write and the wrap that transfers the buffer into the active register. The bench starts the timer with undivided ticks and counts cycles so that a new duty write is sampled on exactly the wrap edge. It then checks three things: the readback still shows the old value, the following period's high time matches the old duty, and the new value appears only after the next wrap. A second overlap is a control write made while running, which must leave the match timing of the current period untouched.

// File: rtl/pwm8_timer.sv
module pwm8_timer #(
  parameter int W  = 8,
  parameter int PW = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         slow_en,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  output logic         pwm_out,
  output logic         irq
);
  logic [4:0]    ctrl;
  logic [W-1:0]  cnt, act, buf_q;
  logic [PW-1:0] pre;
  logic          ff, src_tick;

  wire run     = ctrl[0];
  wire ctrl_wr = wr_en & wr_sel;
  wire duty_wr = wr_en & ~wr_sel;
  wire tick    = run & src_tick;
  wire ovf     = tick & (&cnt);
  wire hit     = tick & (cnt == act);

  always_comb begin
    case (ctrl[4:2])
      3'd0:    src_tick = &pre[10:0];
      3'd1:    src_tick = &pre[6:0];
      3'd2:    src_tick = &pre[4:0];
      3'd3:    src_tick = &pre[2:0];
      3'd4:    src_tick = pre[0];
      3'd5:    src_tick = 1'b1;
      default: src_tick = slow_en;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      cnt   <= '0;
      act   <= '0;
      buf_q <= '0;
      pre   <= '0;
      ff    <= 1'b0;
      irq   <= 1'b0;
    end else begin
      pre <= run ? pre + 1'b1 : '0;
      irq <= ovf;
      if (ctrl_wr) ctrl <= wr_data[4:0];
      if (duty_wr) buf_q <= wr_data;
      if (!run || ovf) act <= buf_q;
      if (ctrl_wr && !run) begin
        cnt <= '0;
        ff  <= wr_data[1];
      end else begin
        if (tick) cnt <= cnt + 1'b1;
        if (hit ^ ovf) ff <= ~ff;
      end
    end
  end

  assign pwm_out = ~ff;
  assign rd_data = rd_sel ? {{(W-5){1'b0}}, ctrl} : act;

  p_irq_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_wrap_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt == '0) && irq);
  p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ovf) |=> $stable(act));
  p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ctrl_wr) |=> $stable(pwm_out));
  p_start_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !run) |=> (cnt == '0) && (pwm_out == !$past(wr_data[1])));
  p_run_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && run && !tick) |=> $stable(pwm_out));
endmodule

// File: tb/pwm8_timer_test.sv
`timescale 1ns/100ps
module pwm8_timer_test;
  logic clk = 1'b0, rst_n = 1'b0, slow_en = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic pwm_out, irq;
  int errors = 0, checks = 0;
  bit done = 0;

  pwm8_timer uut (.clk, .rst_n, .slow_en, .wr_en, .wr_sel, .wr_data,
                  .rd_sel, .rd_data, .pwm_out, .irq);

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] cb(input int sel, input bit init, input bit run);
    return {3'b000, sel[2:0], init, run};
  endfunction

  task automatic start(input int d, input bit i, input int sel);
    wr(1'b1, cb(sel, i, 1'b0));
    wr(1'b0, d[7:0]);
    @(negedge clk);
    wr(1'b1, cb(sel, i, 1'b1));
  endtask

  task automatic measure(input int d, input bit i, input int n, input string req);
    int hi = 0, stray = 0;
    for (int j = 0; j < 256 * n; j++) begin
      if (pwm_out == !i) hi++;
      if (j > 0 && irq) stray++;
      @(negedge clk);
    end
    check(hi == (d == 255 ? 256 : d + 1) * n, {req, " R1 high time"}, hi, (d == 255 ? 256 : d + 1) * n);
    check(stray == 0 && irq == 1'b1, {req, " R2 irq at wrap"}, irq, 1);
    check(pwm_out == !i, {req, " R2 level after wrap"}, pwm_out, !i);
    @(negedge clk);
    check(irq == 1'b0, {req, " R2 irq one cycle"}, irq, 0);
  endtask

  task automatic t_reset;
    rd_sel = 1'b0;
    check(pwm_out == 1'b1, "R9 pwm", pwm_out, 1);
    check(irq == 1'b0, "R9 irq", irq, 0);
    check(rd_data == 8'd0, "R9 duty", rd_data, 0);
    rd_sel = 1'b1; #0.1;
    check(rd_data == 8'd0, "R9 ctrl", rd_data, 0);
    rd_sel = 1'b0;
  endtask

  task automatic t_duty_sweep;
    int dv[4] = '{0, 1, 128, 255};
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < 4; k++) begin
        start(dv[k], p[0], 5);
        measure(dv[k], p[0], 1, "R1 R8 sweep");
      end
  endtask

  task automatic t_divided;
    start(128, 1'b0, 3);
    measure(128, 1'b0, 8, "R3 div8");
    start(100, 1'b1, 4);
    measure(100, 1'b1, 2, "R3 div2");
  endtask

  task automatic t_deferred;
    start(10, 1'b0, 5);
    repeat (100) @(negedge clk);
    wr(1'b0, 8'd200);
    check(rd_data == 8'd10, "R4 readback before wrap", rd_data, 10);
    repeat (155) @(negedge clk);
    check(rd_data == 8'd200, "R4 readback after wrap", rd_data, 200);
    measure(200, 1'b0, 1, "R4 new period");
  endtask

  task automatic t_collision;
    start(20, 1'b0, 5);
    repeat (255) @(negedge clk);
    wr(1'b0, 8'd50);
    check(rd_data == 8'd20, "R6 old value transferred", rd_data, 20);
    measure(20, 1'b0, 1, "R6 period uses old");
    check(rd_data == 8'd50, "R6 pending moved next wrap", rd_data, 50);
  endtask

  task automatic t_stop_hold;
    int bad = 0;
    start(128, 1'b0, 5);
    repeat (200) @(negedge clk);
    check(pwm_out == 1'b0, "R1 after match", pwm_out, 0);
    wr(1'b1, cb(5, 1'b0, 1'b0));
    for (int j = 0; j < 50; j++) begin
      if (pwm_out != 1'b0) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R7 stopped hold", bad, 0);
    rd_sel = 1'b1; #0.1;
    check(rd_data == 8'h14, "R8 ctrl readback", rd_data, 8'h14);
    rd_sel = 1'b0;
    wr(1'b0, 8'd77);
    @(negedge clk);
    check(rd_data == 8'd77, "R5 stopped write immediate", rd_data, 77);
  endtask

  task automatic t_run_ctrl;
    start(128, 1'b0, 5);
    repeat (50) @(negedge clk);
    wr(1'b1, cb(5, 1'b1, 1'b1));
    check(pwm_out == 1'b1, "R7 running ctrl write", pwm_out, 1);
    repeat (77) @(negedge clk);
    check(pwm_out == 1'b1, "R7 before match", pwm_out, 1);
    @(negedge clk);
    check(pwm_out == 1'b0, "R7 match timing kept", pwm_out, 0);
    rd_sel = 1'b1; #0.1;
    check(rd_data == 8'h17, "R8 ctrl readback running", rd_data, 8'h17);
    rd_sel = 1'b0;
  endtask

  task automatic t_slow;
    start(0, 1'b1, 6);
    check(pwm_out == 1'b0, "R8 start level", pwm_out, 0);
    repeat (20) @(negedge clk);
    check(pwm_out == 1'b0, "R3 no slow tick", pwm_out, 0);
    slow_en = 1'b1;
    @(negedge clk);
    slow_en = 1'b0;
    check(pwm_out == 1'b1, "R3 slow tick match D=0", pwm_out, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_duty_sweep;
    t_divided;
    t_deferred;
    t_collision;
    t_stop_hold;
    t_run_ctrl;
    t_slow;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule